// File: doc/BRIEF.md
# Stochastic Roberts Cross Edge Magnitude Unit

This unit computes the Roberts cross edge magnitude for one 2x2 window of 8-bit pixels. It does the arithmetic on unary bitstreams instead of binary words. A single start pulse captures the four pixels. Each pixel then becomes a bitstream whose density of ones equals pixel/256, and all four streams are compared against one shared pseudo-random byte. Because the streams are fully correlated, an XOR of two of them yields the absolute difference of their values. A 2:1 multiplexer, steered by an independent stream of density one half, forms half the sum of the two differences.

A counter totals the ones at the multiplexer output over the stream length. It scales that total back to an 8-bit edge value and raises a one-cycle done pulse. The stream length is a parameter: 1024 cycles is the default, and 256 is a shorter, coarser variant. Both generators are reseeded at every start, so a given window always yields the same result. The surrounding image pipeline supplies the windows. This unit holds no frame or line storage.

Top module: `stoch_edge_top`

## Requirements
- R1: A start pulse while idle captures the four pixels (TL, TR, BL, BR). Pixel changes after that cycle have no effect on the result of the window in progress.
- R2: The pixel generator is a 16-bit shift-left register. Its new bit 0 is the XOR of bits 15, 14, 12 and 3, and it is loaded with 16'hACE1 at start. Each pixel stream bit is 1 when the pixel is greater than bits 7:0 of the register, and all four pixels share the same register.
- R3: The select generator is a 17-bit shift-left register. Its new bit 0 is the XOR of bits 16 and 13, and it is loaded with 17'h1B5A3 at start. Its bit 16 chooses (TR xor BL) when 1 and (TL xor BR) when 0.
- R4: Over N stream cycles the output ones are counted. edgeOut equals count shifted right by log2(N)-8, saturated at 255. It holds its value until the next result and is 0 after reset.
- R5: done is high for exactly one cycle, N+1 clock edges after the edge that accepted start, and edgeOut takes the new value at that same edge. done is 0 after reset.
- R6: A start pulse while a window is in progress is ignored.
- R7: A window whose four pixels are equal gives edgeOut = 0.
- R8: At N=1024, for a window with small differences, edgeOut is within 16 of the ideal value 0.5(|TL-BR|+|TR-BL|).
- R9: With N=256, the shift is 0 and the same rules hold, with a tolerance of 32 for R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a window; ignored while busy |
| pixTL | input | 8 | Top-left pixel |
| pixTR | input | 8 | Top-right pixel |
| pixBL | input | 8 | Bottom-left pixel |
| pixBR | input | 8 | Bottom-right pixel |
| edgeOut | output | 8 | Edge magnitude of the last window |
| done | output | 1 | One-cycle pulse when edgeOut is updated |

## Verification
The assertions check the following on every cycle:
- done is a single-cycle pulse that ends a busy period.
- edgeOut holds whenever done is low.
- A busy period runs uninterrupted until its final bit.
- A window with four equal pixels yields zero.

The remaining behaviour needs the bench's scenarios. The exact stream arithmetic is compared against a behavioural model of both generators. The bench also changes pixels and pulses start mid-window, checks the result against the ideal magnitude within a tolerance, and checks the short-stream variant.

// File: rtl/stoch_edge_pkg.sv
package stoch_edge_pkg;
  typedef struct packed {
    logic load;    // capture pixels, reseed, clear count
    logic step;    // consume one stream bit
    logic finish;  // this step is the last one
  } ctrlStrobe_t;
endpackage

// File: rtl/stoch_edge_lfsr.sv
module stoch_edge_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reload,
  input  logic         advance,
  output logic [W-1:0] state
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        state <= SEED;
    else if (reload)  state <= SEED;
    else if (advance) state <= {state[W-2:0], ^(state & TAPS)};
  end
endmodule

// File: rtl/stoch_edge_ctrl.sv
module stoch_edge_ctrl
  import stoch_edge_pkg::*;
#(
  parameter int STREAM_LEN = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        busy,
  output ctrlStrobe_t strobe
);
  localparam int IDX_W = $clog2(STREAM_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STREAM_LEN - 1);

  logic [IDX_W-1:0] bitIdx;

  always_comb begin
    strobe.load   = start && !busy;
    strobe.step   = busy;
    strobe.finish = busy && (bitIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitIdx <= '0;
    end else if (strobe.load) begin
      busy   <= 1'b1;
      bitIdx <= '0;
    end else if (strobe.finish) begin
      busy   <= 1'b0;
    end else if (strobe.step) begin
      bitIdx <= bitIdx + 1'b1;
    end
  end
endmodule

// File: rtl/stoch_edge_datapath.sv
module stoch_edge_datapath
  import stoch_edge_pkg::*;
#(
  parameter int STREAM_LEN = 1024,
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic [3:0][PIX_W-1:0] pixIn,   // 0 TL, 1 TR, 2 BL, 3 BR
  output logic [PIX_W-1:0]      edgeOut,
  output logic                  done
);
  localparam int CNT_W = $clog2(STREAM_LEN) + 1;
  localparam int SHIFT = $clog2(STREAM_LEN) - PIX_W;
  localparam int PIX_LFSR_W = 16;
  localparam int SEL_LFSR_W = 17;

  logic [3:0][PIX_W-1:0]   pixHeld;
  logic [PIX_LFSR_W-1:0]   pixRand;
  logic [SEL_LFSR_W-1:0]   selRand;
  logic [3:0]              pixBit;
  logic                    diffMain, diffAnti, outBit;
  logic [CNT_W-1:0]        onesCnt, nextCnt, scaled;

  stoch_edge_lfsr #(.W(PIX_LFSR_W), .TAPS(16'hD008), .SEED(16'hACE1)) pixGen (
    .clk(clk), .rstN(rstN), .reload(strobe.load), .advance(strobe.step),
    .state(pixRand));

  stoch_edge_lfsr #(.W(SEL_LFSR_W), .TAPS(17'h12000), .SEED(17'h1B5A3)) selGen (
    .clk(clk), .rstN(rstN), .reload(strobe.load), .advance(strobe.step),
    .state(selRand));

  for (genvar p = 0; p < 4; p++) begin : g_cmp
    assign pixBit[p] = pixHeld[p] > pixRand[PIX_W-1:0];
  end

  always_comb begin
    diffMain = pixBit[0] ^ pixBit[3];
    diffAnti = pixBit[1] ^ pixBit[2];
    outBit   = selRand[SEL_LFSR_W-1] ? diffAnti : diffMain;
    nextCnt  = onesCnt + CNT_W'(outBit);
    scaled   = nextCnt >> SHIFT;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixHeld <= '0;
      onesCnt <= '0;
      edgeOut <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      if (strobe.load) begin
        pixHeld <= pixIn;
        onesCnt <= '0;
      end else if (strobe.step) begin
        onesCnt <= nextCnt;
      end
      if (strobe.finish)
        edgeOut <= (scaled > CNT_W'({PIX_W{1'b1}})) ? {PIX_W{1'b1}} : scaled[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/stoch_edge_top.sv
module stoch_edge_top
  import stoch_edge_pkg::*;
#(
  parameter int STREAM_LEN = 1024,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [PIX_W-1:0] pixTL,
  input  logic [PIX_W-1:0] pixTR,
  input  logic [PIX_W-1:0] pixBL,
  input  logic [PIX_W-1:0] pixBR,
  output logic [PIX_W-1:0] edgeOut,
  output logic             done
);
  ctrlStrobe_t strobe;
  logic        busyNow;

  stoch_edge_ctrl #(.STREAM_LEN(STREAM_LEN)) ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busy(busyNow), .strobe(strobe));

  stoch_edge_datapath #(.STREAM_LEN(STREAM_LEN), .PIX_W(PIX_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pixIn({pixBR, pixBL, pixTR, pixTL}),
    .edgeOut(edgeOut), .done(done));
endmodule

// File: rtl/stoch_edge_chk.sv
module stoch_edge_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busyNow,
  input logic             finish,
  input logic             done,
  input logic [PIX_W-1:0] edgeOut,
  input logic [PIX_W-1:0] pixTL,
  input logic [PIX_W-1:0] pixTR,
  input logic [PIX_W-1:0] pixBL,
  input logic [PIX_W-1:0] pixBR
);
  logic uniformWin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) uniformWin <= 1'b0;
    else if (start && !busyNow)
      uniformWin <= (pixTL == pixTR) && (pixTL == pixBL) && (pixTL == pixBR);
  end

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busyNow && $past(busyNow)));

  a_r4_edge_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(edgeOut));

  a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busyNow && !finish) |=> busyNow);

  a_r7_uniform_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && uniformWin) |-> (edgeOut == '0));
endmodule

bind stoch_edge_top stoch_edge_chk #(.PIX_W(PIX_W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .busyNow(busyNow),
  .finish(strobe.finish), .done(done), .edgeOut(edgeOut),
  .pixTL(pixTL), .pixTR(pixTR), .pixBL(pixBL), .pixBR(pixBR));

// File: tb/stoch_edge_top_test.sv
module stoch_edge_top_test;
  localparam int N_LONG  = 1024;
  localparam int N_SHORT = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, startShort = 1'b0;
  logic [7:0] pTL = 0, pTR = 0, pBL = 0, pBR = 0;
  logic [7:0] edgeOut, edgeShort;
  logic done, doneShort;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  stoch_edge_top #(.STREAM_LEN(N_LONG)) uut (
    .clk(clk), .rstN(rstN), .start(start), .pixTL(pTL), .pixTR(pTR),
    .pixBL(pBL), .pixBR(pBR), .edgeOut(edgeOut), .done(done));

  stoch_edge_top #(.STREAM_LEN(N_SHORT)) uutShort (
    .clk(clk), .rstN(rstN), .start(startShort), .pixTL(pTL), .pixTR(pTR),
    .pixBL(pBL), .pixBR(pBR), .edgeOut(edgeShort), .done(doneShort));

  // Behavioural value model from R2, R3, R4
  function automatic int refEdge(int a, int b, int c, int d, int n);
    logic [15:0] lp = 16'hACE1;
    logic [16:0] ls = 17'h1B5A3;
    int cnt = 0, sh = 0, r;
    int byteV, sa, sb, sc, sd;
    for (int i = 0; i < n; i++) begin
      byteV = int'(lp[7:0]);
      sa = (a > byteV); sb = (b > byteV); sc = (c > byteV); sd = (d > byteV);
      cnt += ls[16] ? (sb ^ sc) : (sa ^ sd);
      lp = {lp[14:0], lp[15] ^ lp[14] ^ lp[12] ^ lp[3]};
      ls = {ls[15:0], ls[16] ^ ls[13]};
    end
    for (int m = n; m > 256; m = m / 2) sh++;
    r = cnt >> sh;
    return (r > 255) ? 255 : r;
  endfunction

  function automatic int absI(int x);
    return (x < 0) ? -x : x;
  endfunction

  // Cycle-by-cycle timing model for uut (R5, R6, R4)
  int remain = 0, pending = 0, expEdge = 0;
  logic expDone = 1'b0;
  always @(posedge clk) begin
    if (!rstN) begin
      remain = 0; expEdge = 0; expDone = 1'b0;
    end else begin
      expDone = 1'b0;
      if (remain > 0) begin
        remain--;
        if (remain == 0) begin expDone = 1'b1; expEdge = pending; end
      end else if (start) begin
        remain  = N_LONG;
        pending = refEdge(pTL, pTR, pBL, pBR, N_LONG);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      checks++;
      if (done !== expDone || int'(edgeOut) != expEdge) begin
        errors++;
        $display("FAIL R5/R4 per-cycle: done=%0b edge=%0d expected done=%0b edge=%0d",
                 done, edgeOut, expDone, expEdge);
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkNear(string tag, int act, int ideal, int tol);
    checks++;
    if (absI(act - ideal) > tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d +/- %0d", tag, act, ideal, tol);
    end
  endtask

  task automatic setPix(int a, int b, int c, int d);
    pTL = 8'(a); pTR = 8'(b); pBL = 8'(c); pBR = 8'(d);
  endtask

  // Returns at the negedge where done is expected high (R5)
  task automatic runLong(int a, int b, int c, int d);
    @(negedge clk); setPix(a, b, c, d); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (N_LONG) @(negedge clk);
  endtask

  task automatic runShort(int a, int b, int c, int d);
    @(negedge clk); setPix(a, b, c, d); startShort = 1'b1;
    @(negedge clk); startShort = 1'b0;
    repeat (N_SHORT) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R4 reset edgeOut", int'(edgeOut), 0);
    check("R5 reset done", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7 uniform windows
    runLong(128, 128, 128, 128);
    check("R5 done at N+1 edges", int'(done), 1);
    check("R7 uniform 128", int'(edgeOut), 0);
    @(negedge clk);
    check("R5 done drops", int'(done), 0);
    runLong(200, 200, 200, 200);
    check("R7 uniform 200", int'(edgeOut), 0);

    // R2 R3 R4 exact arithmetic, strong edge
    runLong(255, 0, 255, 0);
    check("R2/R3 strong edge exact", int'(edgeOut), refEdge(255, 0, 255, 0, N_LONG));
    runLong(30, 220, 90, 160);
    check("R2/R3/R4 mixed exact", int'(edgeOut), refEdge(30, 220, 90, 160, N_LONG));

    // R8 accuracy
    runLong(140, 100, 110, 120);
    check("R8 exact", int'(edgeOut), refEdge(140, 100, 110, 120, N_LONG));
    checkNear("R8 near ideal", int'(edgeOut), 15, 16);

    // R1 and R6: pixels change and start repeats mid-window
    @(negedge clk); setPix(10, 250, 240, 20); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    setPix(128, 128, 128, 128); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (N_LONG - 101) @(negedge clk);
    check("R6 no early done", int'(done), 1);
    check("R1/R6 first window kept", int'(edgeOut), refEdge(10, 250, 240, 20, N_LONG));
    @(negedge clk);
    check("R4 edge held after done", int'(edgeOut), refEdge(10, 250, 240, 20, N_LONG));

    // R9 short stream variant
    runShort(128, 128, 128, 128);
    check("R9 short done", int'(doneShort), 1);
    check("R9/R7 short uniform", int'(edgeShort), 0);
    runShort(140, 100, 110, 120);
    check("R9 short exact", int'(edgeShort), refEdge(140, 100, 110, 120, N_SHORT));
    checkNear("R9/R8 short near ideal", int'(edgeShort), 15, 32);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule